// File: doc/BRIEF.md
# Indirect-Addressed SCSI Controller Register Port

This block is the host-side register interface of a simple SCSI bus controller. The host reaches it through two byte-wide ports. A write to the address port loads an internal register pointer. A read of the address port returns an auxiliary status byte. The value port reads or writes whichever register the pointer selects. After each write through the value port, the pointer steps to the next register. A run of writes therefore fills neighbouring registers, such as the three transfer-count bytes, without reloading the pointer.

Writes to the command register are decoded into three commands: reset, select-with-attention and transfer-info. Commands do not drive a real bus. Each one loads a completion code into the controller status register and raises an interrupt-pending flag. A transfer-info command arms a byte counter. Bytes then written to the data register are collected into a small command buffer. When the last byte arrives, the transfer completes and the buffer and its length are handed on through output ports. Misplaced data bytes are dropped and recorded in a sticky error bit. The interrupt output is a registered copy of the pending flag.

Top module: `scsi_regport`

## Requirements
- R1: A write to the address port (`bus_port`=0) sets the pointer to the low 5 bits of the written byte. A read of the address port returns the auxiliary byte. In that byte, bit 0 is always 1, bit 1 is the sticky error bit, bit 7 is interrupt-pending and the other bits are 0.
- R2: A write to the value port (`bus_port`=1) stores the byte in register[pointer] and then increments the pointer, wrapping from 31 to 0. A read of the value port returns register[pointer] and leaves the pointer unchanged.
- R3: Writing command field 0x00 (reset) to register 0x18 sets interrupt-pending. It also loads status register 0x17 with 0x01, clears the error bit and cancels any transfer in progress.
- R4: Writing command field 0x06 (select-with-attention) sets interrupt-pending. If `tgt_present[reg0x15[2:0]]` is 1, status becomes 0x8A (service required 0x88 with command phase 2). If it is 0, status becomes 0x42 (selection timeout).
- R5: Writing command field 0x20 (transfer-info) latches count = reg0x12<<16 | reg0x13<<8 | reg0x14. It resets the byte index to 0 and clears interrupt-pending. The transfer becomes active only if the count is non-zero.
- R6: While a transfer is active, each value-port write to data register 0x19 stores the byte at the current index and advances the index. The write that brings the index to the count has four effects. It ends the transfer and sets interrupt-pending. It loads status with 0x11 (transfer complete 0x10 with data-in phase 1). It sets `cmd_len` to the count. `cmd_buf` byte i then holds the i-th data byte.
- R7: A data-register write made while no transfer is active is dropped and sets the sticky error bit. So is a byte whose index is 16 or more: it is not stored and sets the error bit, but it still advances the index.
- R8: A value-port read of status register 0x17 clears interrupt-pending.
- R9: A write to control register 0x01 with bit 3 set clears interrupt-pending. With bit 3 clear, interrupt-pending is unchanged.
- R10: Bit 7 of the command byte takes no part in command decoding: 0x80, 0x86 and 0xA0 act as 0x00, 0x06 and 0x20.
- R11: `irq` equals the interrupt-pending flag of the previous clock cycle. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_port | input | 1 | 0 = address/status port, 1 = value port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the port currently addressed |
| tgt_present | input | TGT_N (8) | One bit per target ID, 1 = target present |
| irq | output | 1 | Registered interrupt request |
| cmd_len | output | 24 | Byte count of the last completed transfer |
| cmd_buf | output | BUF_DEPTH*8 (128) | Collected bytes, byte i in bits 8i+7:8i |

## Verification
The bench builds the block with its defaults: a 5-bit pointer over 32 registers, a 16-byte command buffer and 8 target IDs. With these values the pointer wraps from 31 to 0 after a single write. A transfer count of 18 pushes two bytes past the buffer end, so the drop-and-flag path is reached with short transfers. With eight targets, a few directed select commands cover both a present and an absent target.

// File: rtl/scsi_regport_pkg.sv
package scsi_regport_pkg;

  // register map (pointer auto-increment makes the count bytes adjacent)
  localparam int REG_CTRL   = 8'h01;
  localparam int REG_CNT_HI = 8'h12;
  localparam int REG_CNT_MD = 8'h13;
  localparam int REG_CNT_LO = 8'h14;
  localparam int REG_SELID  = 8'h15;
  localparam int REG_STATUS = 8'h17;
  localparam int REG_CMD    = 8'h18;
  localparam int REG_DATA   = 8'h19;

  localparam int CTRL_EOD_BIT = 3;

  localparam logic [7:0] ST_RESET_DONE  = 8'h01;
  localparam logic [7:0] ST_SEL_TIMEOUT = 8'h42;
  localparam logic [7:0] ST_SERVICE     = 8'h88;
  localparam logic [7:0] ST_XFER_DONE   = 8'h10;
  localparam logic [2:0] PH_DATA_IN     = 3'd1;
  localparam logic [2:0] PH_COMMAND     = 3'd2;

  typedef enum logic [1:0] {
    DEC_NONE,
    DEC_RESET,
    DEC_SELATN,
    DEC_XFER
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [7:0] b);
    case (b[6:0])
      7'h00:   decode_cmd = DEC_RESET;
      7'h06:   decode_cmd = DEC_SELATN;
      7'h20:   decode_cmd = DEC_XFER;
      default: decode_cmd = DEC_NONE;
    endcase
  endfunction

  function automatic logic [23:0] count24(input logic [7:0] hi, input logic [7:0] md,
                                          input logic [7:0] lo);
    count24 = {hi, md, lo};
  endfunction

  function automatic logic [7:0] aux_byte(input logic pend, input logic err);
    aux_byte = {pend, 5'b00000, err, 1'b1};
  endfunction

  function automatic logic [7:0] sel_status(input logic present);
    sel_status = present ? (ST_SERVICE | {5'b00000, PH_COMMAND}) : ST_SEL_TIMEOUT;
  endfunction

  function automatic logic [7:0] xfer_status();
    xfer_status = ST_XFER_DONE | {5'b00000, PH_DATA_IN};
  endfunction

endpackage

// File: rtl/srp_regfile.sv
module srp_regfile #(
  parameter int AW     = 5,
  parameter int DW     = 8,
  parameter int ST_IDX = 23,
  localparam int NREG  = 1 << AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     st_we,
  input  logic [DW-1:0]            st_data,
  output logic [NREG-1:0][DW-1:0]  q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (st_we && i == ST_IDX)
          q[i] <= st_data;
        else if (wr_en && wr_addr == AW'(i))
          q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/srp_xfer_buf.sv
module srp_xfer_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 24,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CW-1:0]            start_cnt,
  input  logic                     abort,
  input  logic                     wr,
  input  logic [DW-1:0]            wr_data,
  output logic                     active,
  output logic                     done,
  output logic                     drop,
  output logic [CW-1:0]            len_q,
  output logic [DEPTH*DW-1:0]      buf_flat
);

  logic [CW-1:0]              idx;
  logic [CW-1:0]              cnt;
  logic [DEPTH-1:0][DW-1:0]   mem;
  logic                       in_range;
  logic                       store;

  assign in_range = idx < CW'(DEPTH);
  assign store    = wr && active && in_range;
  assign drop     = wr && (!active || !in_range);
  assign done     = wr && active && (idx + CW'(1) == cnt);
  assign buf_flat = mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      len_q  <= '0;
      mem    <= '0;
    end else begin
      if (store)
        mem[idx[IW-1:0]] <= wr_data;
      if (start) begin
        active <= (start_cnt != '0);
        cnt    <= start_cnt;
        idx    <= '0;
      end else if (abort) begin
        active <= 1'b0;
      end else if (wr && active) begin
        idx <= idx + CW'(1);
        if (done) begin
          active <= 1'b0;
          len_q  <= cnt;
        end
      end
    end
  end

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> idx < cnt);

  // R7
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !active) |=> (!active && idx == $past(idx)));

endmodule

// File: rtl/scsi_regport.sv
module scsi_regport
  import scsi_regport_pkg::*;
#(
  parameter int AW        = 5,
  parameter int BUF_DEPTH = 16,
  parameter int TGT_N     = 8,
  localparam int DW       = 8,
  localparam int CW       = 24,
  localparam int NREG     = 1 << AW,
  localparam int TW       = $clog2(TGT_N)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_cs,
  input  logic                      bus_we,
  input  logic                      bus_port,
  input  logic [7:0]                bus_wdata,
  output logic [7:0]                bus_rdata,
  input  logic [TGT_N-1:0]          tgt_present,
  output logic                      irq,
  output logic [CW-1:0]             cmd_len,
  output logic [BUF_DEPTH*DW-1:0]   cmd_buf
);

  logic [AW-1:0]              ptr;
  logic [NREG-1:0][DW-1:0]    regs;
  logic                       pend;
  logic                       err;

  // access events
  logic addr_wr, val_wr, val_rd;
  assign addr_wr = bus_cs &&  bus_we && !bus_port;
  assign val_wr  = bus_cs &&  bus_we &&  bus_port;
  assign val_rd  = bus_cs && !bus_we &&  bus_port;

  // decoded events, named for the assertions
  cmd_e dec;
  logic cmd_wr, ev_reset, ev_sel, ev_xfer;
  logic ctl_ack, st_rd_ack, data_wr;
  logic xb_active, xb_done, xb_drop;
  logic tgt_hit;
  logic st_we;
  logic [7:0] st_data;
  logic [CW-1:0] xfer_cnt;

  assign dec       = decode_cmd(bus_wdata);
  assign cmd_wr    = val_wr && ptr == AW'(REG_CMD);
  assign ev_reset  = cmd_wr && dec == DEC_RESET;
  assign ev_sel    = cmd_wr && dec == DEC_SELATN;
  assign ev_xfer   = cmd_wr && dec == DEC_XFER;
  assign ctl_ack   = val_wr && ptr == AW'(REG_CTRL) && bus_wdata[CTRL_EOD_BIT];
  assign st_rd_ack = val_rd && ptr == AW'(REG_STATUS);
  assign data_wr   = val_wr && ptr == AW'(REG_DATA);

  assign tgt_hit   = tgt_present[regs[REG_SELID][TW-1:0]];
  assign xfer_cnt  = count24(regs[REG_CNT_HI], regs[REG_CNT_MD], regs[REG_CNT_LO]);

  always_comb begin
    st_we   = ev_reset || ev_sel || xb_done;
    st_data = xfer_status();
    if (ev_reset)
      st_data = ST_RESET_DONE;
    else if (ev_sel)
      st_data = sel_status(tgt_hit);
  end

  srp_regfile #(.AW(AW), .DW(DW), .ST_IDX(REG_STATUS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (val_wr),
    .wr_addr (ptr),
    .wr_data (bus_wdata),
    .st_we   (st_we),
    .st_data (st_data),
    .q       (regs)
  );

  srp_xfer_buf #(.DEPTH(BUF_DEPTH), .DW(DW), .CW(CW)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ev_xfer),
    .start_cnt (xfer_cnt),
    .abort     (ev_reset || ev_sel),
    .wr        (data_wr),
    .wr_data   (bus_wdata),
    .active    (xb_active),
    .done      (xb_done),
    .drop      (xb_drop),
    .len_q     (cmd_len),
    .buf_flat  (cmd_buf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      pend <= 1'b0;
      err  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (addr_wr)
        ptr <= bus_wdata[AW-1:0];
      else if (val_wr)
        ptr <= ptr + AW'(1);

      if (ev_reset || ev_sel || xb_done)
        pend <= 1'b1;
      else if (ctl_ack || st_rd_ack || ev_xfer)
        pend <= 1'b0;

      if (ev_reset)
        err <= 1'b0;
      else if (xb_drop)
        err <= 1'b1;

      irq <= pend;
    end
  end

  assign bus_rdata = bus_port ? regs[ptr] : aux_byte(pend, err);

  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ptr == $past(bus_wdata[AW-1:0]));

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    val_wr |=> ptr == $past(ptr) + AW'(1));

  // R3
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset |=> (pend && !err && regs[REG_STATUS] == ST_RESET_DONE));

  // R4
  sel_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel |=> (pend && (regs[REG_STATUS] == 8'h8A || regs[REG_STATUS] == 8'h42)));

  // R6
  xfer_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xb_done |=> (pend && regs[REG_STATUS] == 8'h11 && !xb_active));

  // R8
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd_ack |=> !pend);

  // R11
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xb_done |-> ##2 irq);

endmodule

// File: tb/scsi_regport_test.sv
module scsi_regport_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_cs, bus_we, bus_port;
  logic [7:0]   bus_wdata;
  logic [7:0]   bus_rdata;
  logic [7:0]   tgt_present;
  logic         irq;
  logic [23:0]  cmd_len;
  logic [127:0] cmd_buf;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regport uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tgt_present(tgt_present), .irq(irq), .cmd_len(cmd_len), .cmd_buf(cmd_buf)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model state
  logic [7:0]  m_reg [32];
  int          m_ptr;
  bit          m_pend, m_err, m_act;
  int          m_idx, m_cnt, m_len;
  logic [7:0]  m_buf [16];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_aux();
    return {m_pend, 5'b0, m_err, 1'b1};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
    for (int i = 0; i < 16; i++) m_buf[i] = 8'h00;
    m_ptr = 0; m_pend = 0; m_err = 0; m_act = 0;
    m_idx = 0; m_cnt = 0; m_len = 0;
  endtask

  task automatic model_wr(input bit port, input logic [7:0] d);
    if (!port) begin
      m_ptr = d & 8'h1f;
    end else begin
      m_reg[m_ptr] = d;
      case (m_ptr)
        8'h01: if (d[3]) m_pend = 0;
        8'h18: case (d & 8'h7f)
          8'h00: begin m_pend = 1; m_reg[8'h17] = 8'h01; m_err = 0; m_act = 0; end
          8'h06: begin
            m_pend = 1; m_act = 0;
            m_reg[8'h17] = tgt_present[m_reg[8'h15] & 8'h07] ? 8'h8A : 8'h42;
          end
          8'h20: begin
            m_cnt = {m_reg[8'h12], m_reg[8'h13], m_reg[8'h14]};
            m_idx = 0; m_pend = 0; m_act = (m_cnt != 0);
          end
          default: ;
        endcase
        8'h19: begin
          if (m_act) begin
            if (m_idx < 16) m_buf[m_idx] = d; else m_err = 1;
            m_idx++;
            if (m_idx == m_cnt) begin
              m_act = 0; m_pend = 1; m_reg[8'h17] = 8'h11; m_len = m_cnt;
            end
          end else begin
            m_err = 1;
          end
        end
        default: ;
      endcase
      m_ptr = (m_ptr + 1) & 31;
    end
  endtask

  task automatic bus_write(input bit port, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_we = 1; bus_port = port; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_we = 0;
    model_wr(port, d);
  endtask

  task automatic bus_read(input bit port, output logic [7:0] v);
    @(negedge clk);
    bus_cs = 1; bus_we = 0; bus_port = port;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_cs = 0;
    if (port && m_ptr == 8'h17) m_pend = 0;
  endtask

  // read through a port and compare with the model
  task automatic read_chk(input string tag, input bit port);
    logic [7:0] v, e;
    e = port ? m_reg[m_ptr] : exp_aux();
    bus_read(port, v);
    check(tag, v, e);
  endtask

  task automatic idle_irq_chk(input string tag);
    @(negedge clk);
    check(tag, irq, m_pend);
  endtask

  task automatic reg_read_chk(input string tag, input logic [7:0] a, input logic [7:0] e);
    logic [7:0] v;
    bus_write(0, a);
    bus_read(1, v);
    check(tag, v, e);
  endtask

  task automatic set_count(input logic [23:0] c);
    bus_write(0, 8'h12);
    bus_write(1, c[23:16]);
    bus_write(1, c[15:8]);
    bus_write(1, c[7:0]);
  endtask

  task automatic data_byte(input logic [7:0] d);
    bus_write(0, 8'h19);
    bus_write(1, d);
  endtask

  task automatic buf_chk(input string tag, input int n);
    for (int i = 0; i < n && i < 16; i++)
      check(tag, cmd_buf[i*8 +: 8], m_buf[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    void'($urandom(32'h5eed1234));
    bus_cs = 0; bus_we = 0; bus_port = 0; bus_wdata = 0;
    tgt_present = 8'b0010_0100;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    check("R1 reset aux", bus_rdata, 8'h01);
    check("R11 reset irq", irq, 1'b0);
    check("R6 reset len", cmd_len, 24'h0);
    read_chk("R2 reset reg0", 1);

    // R1 pointer masking
    bus_write(0, 8'h25);
    bus_write(1, 8'hA5);
    reg_read_chk("R1 masked pointer", 8'h05, 8'hA5);

    // R2 wrap from 31 to 0, read does not move pointer
    bus_write(0, 8'h1f);
    bus_write(1, 8'h3C);
    bus_write(1, 8'h77);
    reg_read_chk("R2 wrap reg0", 8'h00, 8'h77);
    bus_read(1, v2);
    check("R2 read keeps pointer", v2, 8'h77);
    reg_read_chk("R2 reg31", 8'h1f, 8'h3C);

    // R3 reset command, R11 irq delay, R8 status read clears
    bus_write(0, 8'h18);
    bus_write(1, 8'h00);
    check("R11 irq lags pend", irq, 1'b0);
    read_chk("R3 aux after reset cmd", 0);
    idle_irq_chk("R11 irq follows pend");
    reg_read_chk("R3 status code", 8'h17, 8'h01);
    read_chk("R8 aux after status read", 0);
    idle_irq_chk("R8 irq after clear");

    // R4 select present / absent, R10 flag bit ignored
    bus_write(0, 8'h15); bus_write(1, 8'h02);
    bus_write(0, 8'h18); bus_write(1, 8'h06);
    read_chk("R4 aux pend", 0);
    reg_read_chk("R4 present", 8'h17, 8'h8A);
    bus_write(0, 8'h15); bus_write(1, 8'h03);
    bus_write(0, 8'h18); bus_write(1, 8'h86);
    reg_read_chk("R10 R4 absent", 8'h17, 8'h42);

    // R9 control write
    bus_write(0, 8'h18); bus_write(1, 8'h00);
    bus_write(0, 8'h01); bus_write(1, 8'h04);
    read_chk("R9 bit3 clear keeps pend", 0);
    bus_write(0, 8'h01); bus_write(1, 8'h08);
    read_chk("R9 bit3 set clears pend", 0);

    // R5 / R6 four-byte transfer
    bus_write(0, 8'h18); bus_write(1, 8'h00);
    set_count(24'd4);
    bus_write(0, 8'h18); bus_write(1, 8'h20);
    read_chk("R5 xfer clears pend", 0);
    data_byte(8'h12); data_byte(8'h34); data_byte(8'h56);
    read_chk("R6 no pend before last", 0);
    data_byte(8'h78);
    read_chk("R6 pend at count", 0);
    check("R6 len", cmd_len, 24'd4);
    buf_chk("R6 buf", 4);
    reg_read_chk("R6 status", 8'h17, 8'h11);
    data_byte(8'h99);
    read_chk("R7 extra byte error", 0);

    // R7 overflow beyond buffer, R10 xfer with flag
    bus_write(0, 8'h18); bus_write(1, 8'h80);
    read_chk("R10 R3 reset clears err", 0);
    set_count(24'd18);
    bus_write(0, 8'h18); bus_write(1, 8'hA0);
    for (int i = 0; i < 17; i++) data_byte(8'(8'h40 + i));
    read_chk("R7 overflow err", 0);
    data_byte(8'hEE);
    check("R7 len 18", cmd_len, 24'd18);
    buf_chk("R7 buf", 16);
    read_chk("R7 aux pend", 0);

    // R5 zero count: transfer never active
    bus_write(0, 8'h18); bus_write(1, 8'h00);
    set_count(24'd0);
    bus_write(0, 8'h18); bus_write(1, 8'h20);
    data_byte(8'h11);
    read_chk("R5 zero count err", 0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      bit pv;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      d = 8'($urandom);
      pv = m_pend;
      if (r < 25) begin
        case ($urandom_range(0, 5))
          0: d = 8'h18; 1: d = 8'h19; 2: d = 8'h17; 3: d = 8'h12; 4: d = 8'h01;
          default: ;
        endcase
        bus_write(0, d);
        check("R1 R11 random irq", irq, pv);
      end else if (r < 70) begin
        if (m_ptr == 8'h18) begin
          case ($urandom_range(0, 5))
            0: d = 8'h00; 1: d = 8'h06; 2: d = 8'h20;
            3: d = 8'h86; 4: d = 8'hA0; default: ;
          endcase
        end else if (m_ptr == 8'h12 || m_ptr == 8'h13) begin
          d = 8'h00;
        end else if (m_ptr == 8'h14) begin
          d = d & 8'h1f;
        end else if (m_ptr == 8'h15) begin
          d = d & 8'h07;
        end
        bus_write(1, d);
        check("R2 R11 random irq", irq, pv);
      end else begin
        read_chk("R2 R8 random read", r[0]);
        check("R8 R11 random irq", irq, pv);
      end
    end
    read_chk("R1 final aux", 0);
    check("R6 final len", cmd_len, m_len);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule